// File: doc/BRIEF.md
# Filtered Ping-Pong Receive Buffer

This block is the receive half of a small Ethernet MAC. Frame bytes arrive one per cycle on a valid/data/last stream. The block stores them in one of two equal receive buffers, which a host reads over a 32-bit word-addressed register bus. The last word of each buffer is not frame storage. It holds that buffer's control word: a full flag and an interrupt enable.

A frame is kept only when its destination passes the filter. That means the group bit of the first byte is set, or the first six bytes match the station address. A frame is also refused when the buffer it would land in is still marked full. The keep/refuse decision is taken on the sixth byte. Until then the header is held in registers, so a refused frame never touches buffer memory. When a kept frame ends, its buffer is marked full and an interrupt pulse may be raised. In ping-pong mode the next frame then goes to the other buffer. The host frees a buffer by rewriting its control word. No frame length is recorded.

Top module: `rx_pingpong_buffer`

## Requirements
- R1: A frame is kept when bit 7 of its first byte is 1, or when its first six bytes equal `station_addr` (first byte compared with bits 47:40, sixth with bits 7:0). Any other frame writes no buffer word, leaves both control words unchanged and raises no interrupt.
- R2: A frame that ends before its sixth byte is discarded with no effect on buffers, control words or `irq`.
- R3: A frame that passes the filter while the active buffer's full flag is 1 is lost. It writes nothing, leaves the flags unchanged, raises no interrupt and does not change the active buffer.
- R4: Byte k of a kept frame is stored in word k/4 of its buffer, at bits [31-8*(k mod 4) -: 8]. A partial last word is still written, with its unused low bytes zero. A six-byte frame stores two words.
- R5: When a kept frame ends, bit 0 (full) of its buffer's control word becomes 1. The stored data and the flag are visible to host reads from the second clock edge after the last byte is sampled.
- R6: A kept frame produces a one-cycle `irq` pulse when bit 3 (interrupt enable) of its buffer's control word is 1 and `irq_global_en` is 1. Otherwise no pulse is produced.
- R7: With `pingpong_en` high, the active buffer switches after every kept frame. With it low, buffer 0 is always used.
- R8: A host write to a control word stores `host_wdata` bits 0 and 3 into the full flag and the interrupt enable; this is how the host clears full. Host writes to data words have no effect.
- R9: Bytes at offset BUF_BYTES-4 and beyond are not stored, so a long frame cannot corrupt the control word. The full flag is still set when such a frame ends.
- R10: `rx_ready` is always 1, so refused frames are drained without backpressure.
- R11: `host_addr` is a word index. Its top bit selects the buffer and its low bits select the word; the last word of each buffer is the control word, read as {28'b0, ien, 2'b0, full}. `host_rdata` is valid in the cycle after `host_re`. After reset both control words read 0, buffer 0 is active and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_valid | input | 1 | Frame byte present |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| rx_ready | output | 1 | Always high |
| station_addr | input | 48 | Station address, first wire byte in bits 47:40 |
| pingpong_en | input | 1 | Alternate between the two buffers |
| irq_global_en | input | 1 | Global interrupt enable |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_addr | input | HOST_AW | Host word index within the receive window |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after the strobe |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench builds the block with BUF_BYTES = 64, which gives 16 words per buffer and puts the control words at indices 15 and 31. With buffers this small, a 70-byte frame runs past the data region within a few dozen cycles. This reaches the truncation boundary and the protection of the control word, which the default 2 KB size would leave far out of reach. The same runs also cover six-byte frames, lost frames in both modes, and ping-pong alternation.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;
  localparam int unsigned FULL_BIT  = 0;
  localparam int unsigned IEN_BIT   = 3;
  localparam int unsigned HDR_BYTES = 6;
endpackage

// File: rtl/rxpp_rst_sync.sv
module rxpp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/rxpp_ram.sv
module rxpp_ram #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  localparam int DEPTH = 1 << AW;
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxpp_packer.sv
module rxpp_packer
  import rxpp_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  localparam int WORDS = BUF_BYTES / 4,
  localparam int WAW = $clog2(WORDS)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [7:0]   in_data,
  input  logic         in_last,
  input  logic [47:0]  station,
  input  logic         act_buf,
  input  logic         act_full,
  output logic         wr_en,
  output logic [WAW:0] wr_addr,
  output logic [31:0]  wr_data,
  output logic         done,
  output logic         done_buf
);
  localparam int CW = $clog2(BUF_BYTES) + 1;
  localparam int DATA_BYTES = BUF_BYTES - 4;

  logic [CW-1:0] cnt_q, cnt_n;
  logic [39:0]   hdr_q, hdr_n;
  logic [31:0]   asm_q, asm_n, asm_in;
  logic          acc_q, acc_n;
  logic          buf_q, buf_n;
  logic          pend_q, pend_n;
  logic [31:0]   pend_data_q, pend_data_n;
  logic          pend_buf_q, pend_buf_n;
  logic          done_q, done_n;
  logic          done_buf_q, done_buf_n;
  logic          decide, pass, take, wr_cur;

  always_comb begin
    asm_in = asm_q;
    case (cnt_q[1:0])
      2'd0: asm_in = {in_data, 24'h0};
      2'd1: asm_in[23:16] = in_data;
      2'd2: asm_in[15:8]  = in_data;
      default: asm_in[7:0] = in_data;
    endcase
  end

  assign decide = in_valid && (cnt_q == CW'(HDR_BYTES - 1));
  assign pass   = hdr_q[39] || ({hdr_q, in_data} == station);
  assign take   = decide && pass && !act_full;
  assign wr_cur = in_valid && acc_q && (cnt_q < CW'(DATA_BYTES))
                  && ((cnt_q[1:0] == 2'd3) || in_last);

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    if (pend_q) begin
      wr_en   = 1'b1;
      wr_addr = {pend_buf_q, WAW'(1)};
      wr_data = pend_data_q;
    end else if (take) begin
      wr_en   = 1'b1;
      wr_addr = {act_buf, WAW'(0)};
      wr_data = hdr_q[39:8];
    end else if (wr_cur) begin
      wr_en   = 1'b1;
      wr_addr = {buf_q, cnt_q[WAW+1:2]};
      wr_data = asm_in;
    end
  end

  always_comb begin
    cnt_n       = cnt_q;
    hdr_n       = hdr_q;
    asm_n       = asm_q;
    acc_n       = acc_q;
    buf_n       = take ? act_buf : buf_q;
    pend_n      = take && in_last;
    pend_data_n = asm_in;
    pend_buf_n  = act_buf;
    done_n      = in_valid && in_last && (acc_q || take);
    done_buf_n  = take ? act_buf : buf_q;
    if (in_valid) begin
      asm_n = asm_in;
      if (cnt_q < CW'(HDR_BYTES - 1)) hdr_n = {hdr_q[31:0], in_data};
      if (in_last) begin
        cnt_n = '0;
        acc_n = 1'b0;
      end else begin
        if (cnt_q != {CW{1'b1}}) cnt_n = cnt_q + 1'b1;
        if (take) acc_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      hdr_q       <= '0;
      asm_q       <= '0;
      acc_q       <= 1'b0;
      buf_q       <= 1'b0;
      pend_q      <= 1'b0;
      pend_data_q <= '0;
      pend_buf_q  <= 1'b0;
      done_q      <= 1'b0;
      done_buf_q  <= 1'b0;
    end else begin
      cnt_q       <= cnt_n;
      hdr_q       <= hdr_n;
      asm_q       <= asm_n;
      acc_q       <= acc_n;
      buf_q       <= buf_n;
      pend_q      <= pend_n;
      pend_data_q <= pend_data_n;
      pend_buf_q  <= pend_buf_n;
      done_q      <= done_n;
      done_buf_q  <= done_buf_n;
    end
  end

  assign done     = done_q;
  assign done_buf = done_buf_q;

  // R9
  ctrl_word_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr[WAW-1:0] != {WAW{1'b1}}));

  // R4
  single_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !(take || wr_cur));
endmodule

// File: rtl/rxpp_ctrl.sv
module rxpp_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pingpong_en,
  input  logic       gie,
  input  logic       done,
  input  logic       done_buf,
  input  logic       host_we,
  input  logic       host_hit,
  input  logic       host_buf,
  input  logic       wr_full,
  input  logic       wr_ien,
  output logic [1:0] full,
  output logic [1:0] ien,
  output logic       act_buf,
  output logic       irq
);
  logic [1:0] full_q, full_n, ien_q, ien_n;
  logic       cur_q, cur_n, irq_q, irq_n;

  always_comb begin
    full_n = full_q;
    ien_n  = ien_q;
    if (host_we && host_hit) begin
      full_n[host_buf] = wr_full;
      ien_n[host_buf]  = wr_ien;
    end
    if (done) full_n[done_buf] = 1'b1;
    cur_n = (done && pingpong_en) ? !cur_q : cur_q;
    irq_n = done && ien_q[done_buf] && gie;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
      ien_q  <= '0;
      cur_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      full_q <= full_n;
      ien_q  <= ien_n;
      cur_q  <= cur_n;
      irq_q  <= irq_n;
    end
  end

  assign full    = full_q;
  assign ien     = ien_q;
  assign act_buf = pingpong_en && cur_q;
  assign irq     = irq_q;

  // R6
  irq_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (|full_q));

  // R6
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  // R7
  pp_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pingpong_en) |=> (!pingpong_en || (cur_q != $past(cur_q))));

  for (genvar b = 0; b < 2; b++) begin : g_hold
    // R8
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q[b] && !(host_we && host_hit && (host_buf == 1'(b)))) |=> full_q[b]);
  end
endmodule

// File: rtl/rx_pingpong_buffer.sv
module rx_pingpong_buffer
  import rxpp_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  localparam int HOST_AW = $clog2(BUF_BYTES / 4) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_valid,
  input  logic [7:0]         rx_data,
  input  logic               rx_last,
  output logic               rx_ready,
  input  logic [47:0]        station_addr,
  input  logic               pingpong_en,
  input  logic               irq_global_en,
  input  logic               host_we,
  input  logic               host_re,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  output logic               irq
);
  localparam int WAW = HOST_AW - 1;

  logic           srst_n;
  logic           wr_en, done, done_buf, act_buf;
  logic [WAW:0]   wr_addr;
  logic [31:0]    wr_data, ram_q;
  logic [1:0]     full, ien;
  logic           host_buf, host_hit;
  logic           sel_ctrl_q;
  logic [31:0]    ctrl_rd_q, ctrl_val;

  assign host_buf = host_addr[HOST_AW-1];
  assign host_hit = &host_addr[WAW-1:0];

  rxpp_rst_sync u_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  rxpp_packer #(.BUF_BYTES(BUF_BYTES)) u_pack (
    .clk      (clk),
    .rst_n    (srst_n),
    .in_valid (rx_valid),
    .in_data  (rx_data),
    .in_last  (rx_last),
    .station  (station_addr),
    .act_buf  (act_buf),
    .act_full (full[act_buf]),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .done     (done),
    .done_buf (done_buf)
  );

  rxpp_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (srst_n),
    .pingpong_en (pingpong_en),
    .gie         (irq_global_en),
    .done        (done),
    .done_buf    (done_buf),
    .host_we     (host_we),
    .host_hit    (host_hit),
    .host_buf    (host_buf),
    .wr_full     (host_wdata[FULL_BIT]),
    .wr_ien      (host_wdata[IEN_BIT]),
    .full        (full),
    .ien         (ien),
    .act_buf     (act_buf),
    .irq         (irq)
  );

  rxpp_ram #(.AW(HOST_AW)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .re    (host_re),
    .raddr (host_addr),
    .rdata (ram_q)
  );

  always_comb begin
    ctrl_val           = '0;
    ctrl_val[FULL_BIT] = full[host_buf];
    ctrl_val[IEN_BIT]  = ien[host_buf];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      sel_ctrl_q <= 1'b0;
      ctrl_rd_q  <= '0;
    end else if (host_re) begin
      sel_ctrl_q <= host_hit;
      ctrl_rd_q  <= ctrl_val;
    end
  end

  assign host_rdata = sel_ctrl_q ? ctrl_rd_q : ram_q;
  assign rx_ready   = 1'b1;
endmodule

// File: tb/tb_rx_pingpong_buffer.sv
module tb_rx_pingpong_buffer;
  localparam int BB  = 64;
  localparam int HAW = 5;
  localparam int C0  = 15;
  localparam int C1  = 31;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_ready;
  logic [47:0] station_addr = 48'h02_11_22_33_44_55;
  logic pingpong_en = 1'b0, irq_global_en = 1'b0;
  logic host_we = 1'b0, host_re = 1'b0;
  logic [HAW-1:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic irq;

  rx_pingpong_buffer #(.BUF_BYTES(BB)) dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_ready(rx_ready), .station_addr(station_addr),
    .pingpong_en(pingpong_en), .irq_global_en(irq_global_en),
    .host_we(host_we), .host_re(host_re), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, irq_cnt = 0, exp_irq = 0;
  bit irq_prev = 1'b0, irq_wide = 1'b0, done_flag = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic rd_pend = 1'b0;
  logic [7:0] fr [0:127];
  int fr_len = 0;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(posedge clk) rd_pend <= host_re;
  always @(negedge clk) begin
    if (rd_pend) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(host_rdata === e, t, host_rdata, e);
    end
  end

  always @(posedge clk) begin
    if (irq === 1'b1) irq_cnt++;
    if (irq === 1'b1 && irq_prev) irq_wide = 1'b1;
    irq_prev = (irq === 1'b1);
  end

  task automatic host_read(int a, logic [31:0] e, string t);
    @(negedge clk);
    host_re = 1'b1; host_addr = HAW'(a);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    host_re = 1'b0;
  endtask

  task automatic host_write(int a, logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = HAW'(a); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  // kind 0: station match, 1: group bit set, 2: unicast mismatch
  task automatic mk(int kind, int len, logic [7:0] seed);
    fr_len = len;
    for (int i = 0; i < len; i++) fr[i] = seed + 8'(i);
    for (int i = 0; i < 6 && i < len; i++) begin
      if (kind != 1) fr[i] = station_addr[47-8*i -: 8];
    end
    if (kind == 1) fr[0] = 8'hA5;
    if (kind == 2 && len > 5) fr[5] = station_addr[7:0] ^ 8'h01;
  endtask

  task automatic send();
    for (int i = 0; i < fr_len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = fr[i]; rx_last = (i == fr_len - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
    check(rx_ready === 1'b1, "R10", {31'b0, rx_ready}, 32'd1);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_word(int k);
    logic [31:0] w = '0;
    for (int j = 0; j < 4; j++)
      if (4*k + j < fr_len) w[31-8*j -: 8] = fr[4*k + j];
    return w;
  endfunction

  task automatic check_words(int base, int n, string t);
    for (int k = 0; k < n; k++) host_read(base + k, exp_word(k), t);
  endtask

  task automatic check_irq(string t);
    check(irq_cnt == exp_irq, t, irq_cnt, exp_irq);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    host_read(C0, 32'd0, "R11");
    host_read(C1, 32'd0, "R11");
    check(irq === 1'b0, "R11", {31'b0, irq}, 32'd0);
    check(rx_ready === 1'b1, "R10", {31'b0, rx_ready}, 32'd1);

    irq_global_en = 1'b1;
    host_write(C0, 32'h8);
    // R1 R4 R5 R6: matching frame
    mk(0, 10, 8'h30); send(); exp_irq++;
    check_irq("R6");
    check_words(0, 3, "R4");
    host_read(C0, 32'h9, "R5");
    // R3: buffer full, frame lost
    mk(0, 12, 8'h50); send();
    check_irq("R3");
    host_read(C0, 32'h9, "R3");
    mk(0, 10, 8'h30); check_words(0, 3, "R3");
    // R1: mismatch discarded
    host_write(C0, 32'h8);
    mk(2, 10, 8'h70); send();
    host_read(C0, 32'h8, "R1");
    check_irq("R1");
    mk(0, 10, 8'h30); check_words(0, 3, "R1");
    // R1 group frame, R4 partial word, R7 buffer 0 only
    mk(1, 7, 8'h90); send(); exp_irq++;
    host_read(C0, 32'h9, "R1");
    check_words(0, 2, "R4");
    host_read(C1, 32'h0, "R7");
    check_irq("R6");
    // R2: short frame
    host_write(C0, 32'h8);
    mk(1, 4, 8'hB0); send();
    host_read(C0, 32'h8, "R2");
    check_irq("R2");
    // R4: exactly six bytes
    mk(0, 6, 8'hC0); send(); exp_irq++;
    host_read(C0, 32'h9, "R4");
    check_words(0, 2, "R4");
    // R7 ping-pong
    pingpong_en = 1'b1;
    host_write(C0, 32'h8);
    host_write(C1, 32'h0);
    mk(0, 9, 8'hD0); send(); exp_irq++;
    mk(1, 13, 8'h10); send();
    check_irq("R6");
    host_read(C1, 32'h1, "R7");
    check_words(16, 4, "R7");
    mk(0, 8, 8'h60); send();
    host_read(C0, 32'h9, "R3");
    mk(0, 9, 8'hD0); check_words(0, 3, "R3");
    // R9 truncation (active buffer still 0 after the lost frame)
    host_write(C0, 32'h8);
    host_write(C1, 32'h0);
    mk(1, 70, 8'h20); send(); exp_irq++;
    host_read(C0, 32'h9, "R9");
    check_words(0, 15, "R9");
    check_irq("R9");
    // R8: data writes ignored, control writes store bits 0 and 3
    host_write(0, 32'hDEADBEEF);
    host_read(0, exp_word(0), "R8");
    host_write(C0, 32'hFFFF_FFF6);
    host_read(C0, 32'h0, "R8");
    host_write(C0, 32'h9);
    host_read(C0, 32'h9, "R8");
    host_write(C0, 32'h0);
    host_read(C0, 32'h0, "R8");
    // R6 global enable off; active buffer is 1
    irq_global_en = 1'b0;
    host_write(C1, 32'h8);
    mk(0, 11, 8'h44); send();
    check_irq("R6");
    host_read(C1, 32'h9, "R5");
    check_words(16, 3, "R5");
    repeat (3) @(negedge clk);
    check(irq_wide == 1'b0, "R6", {31'b0, irq_wide}, 32'd0);
    check(exp_q.size() == 0, "R11", exp_q.size(), 32'd0);
    done_flag = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule